// File: doc/BRIEF.md
# Mode-Aliased Auxiliary Status Slot

This block is one byte-wide register location inside a UART-style peripheral. A mode-select input decides what the location holds. With the select low, it behaves as an 8-bit scratchpad that software can write and read back freely. With the select high, the same location exposes an auxiliary status/control register that gathers consumer-IR events from the transmit and receive datapaths.

Each status bit has its own rules for being set and cleared. Event strobes from the datapaths set the bits. A bit can be cleared by a write-one, by a read, by a FIFO soft reset, or by a transmit-side event. Two of the bits also drive control outputs: the end-of-transmission request and the receiver enable. If a set and a clear reach the same bit in the same cycle, the set wins. The location returns read data combinationally, and it applies the clear-on-read at the clock edge that ends the read cycle.

Top module: `uart_aux_slot`

## Requirements
- R1: With `ext_sel`=0, writes load the 8-bit scratchpad and reads return it. With `ext_sel`=1, the scratchpad keeps its value and the status register is visible on `rdata`.
- R2: After reset, both the status register and the scratchpad read 00h. Bits 7, 3 and 1 of the status register always read 0. Writes to those bits, and to bit 0, have no effect.
- R3: Bit 6 (transmit underrun) is set by `tx_underrun_ev` in consumer-IR mode. It is cleared by writing 1 to bit 6 or by `tx_soft_rst`. Writing 0 has no effect. It reads 0 the cycle after any cycle spent in another mode.
- R4: Bit 6 is not the only transmit bit: bit 2 (end-of-transmission request, also output as `eot_req`) is set by writing 1 to bit 2. It is cleared by `tx_soft_rst`, `tx_eot_sent` or `tx_fifo_wr`.
- R5: Bit 5 (receiver active, also output as `rx_enable`) is set by `rx_pulse_ev`. Writing 1 to bit 5 clears it and deasserts `rx_enable`.
- R6: Bit 4 (reception watchdog) is set by `rx_pulse_ev` and is cleared by a read with `ext_sel`=1.
- R7: Bit 0 (receive timeout) is set by `rx_timeout_ev` only while `rx_below_thr`=1. It is cleared by `rx_fifo_rd`.
- R8: `rx_soft_rst` clears bits 0, 4 and 5.
- R9: When a set event and a clear event hit the same bit in the same cycle, the bit ends up 1.
- R10: Consumer-IR mode is recognized when `mode` equals parameter `CIR_CODE`, which defaults to 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel | input | 1 | 1 selects the status register, 0 selects the scratchpad |
| mode | input | 3 | Operating mode field |
| wr_en | input | 1 | CPU write strobe for this location |
| rd_en | input | 1 | CPU read strobe for this location |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Read data for the selected register |
| tx_underrun_ev | input | 1 | Transmit underrun event |
| tx_soft_rst | input | 1 | Transmitter soft reset |
| tx_eot_sent | input | 1 | Final byte has been sent |
| tx_fifo_wr | input | 1 | Character written into the transmit FIFO |
| rx_pulse_ev | input | 1 | IR pulse or pulse train detected |
| rx_soft_rst | input | 1 | Receiver soft reset |
| rx_timeout_ev | input | 1 | Receive FIFO timeout event |
| rx_below_thr | input | 1 | Receive FIFO level below threshold |
| rx_fifo_rd | input | 1 | Character read from the receive FIFO |
| eot_req | output | 1 | End-of-transmission request (bit 2) |
| rx_enable | output | 1 | Receiver enable (bit 5) |

## Verification
The collisions that matter are a status set and a clear landing on the same bit in the same edge. The bench provokes several of these:
- a pulse detection in the same cycle as a read of the watchdog bit;
- a timeout in the same cycle as a receiver soft reset;
- a CPU write of the end-of-transmission bit in the same cycle as a transmit FIFO write.

Each collision is judged by peeking at the register in the following idle cycle. The set bit must read 1, while the other bits touched only by the clear must read 0.

// File: rtl/uart_aux_pkg.sv
package uart_aux_pkg;
  localparam int unsigned W = 8;
  localparam int unsigned B_TOUT  = 0;
  localparam int unsigned B_EOT   = 2;
  localparam int unsigned B_WDG   = 4;
  localparam int unsigned B_RXACT = 5;
  localparam int unsigned B_UR    = 6;
  localparam logic [W-1:0] IMPL_MASK = 8'b0111_0101;
endpackage

// File: rtl/uart_aux_flag.sv
module uart_aux_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o); // R9
endmodule

// File: rtl/uart_aux_scratch.sv
module uart_aux_scratch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_d;

  always_comb q_d = we_i ? d_i : q_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

  AST_SCRATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o)); // R1
endmodule

// File: rtl/uart_aux_slot.sv
module uart_aux_slot
  import uart_aux_pkg::*;
#(
  parameter logic [2:0] CIR_CODE = 3'b010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_sel,
  input  logic [2:0]   mode,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         tx_underrun_ev,
  input  logic         tx_soft_rst,
  input  logic         tx_eot_sent,
  input  logic         tx_fifo_wr,
  input  logic         rx_pulse_ev,
  input  logic         rx_soft_rst,
  input  logic         rx_timeout_ev,
  input  logic         rx_below_thr,
  input  logic         rx_fifo_rd,
  output logic         eot_req,
  output logic         rx_enable
);
  logic [1:0]   rst_sync_q;
  logic         rst_int_n;
  logic         cir;
  logic         aux_wr;
  logic         aux_rd;
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;
  logic [W-1:0] aux_q;
  logic [W-1:0] scr_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cir    = (mode == CIR_CODE);
  assign aux_wr = wr_en && ext_sel;
  assign aux_rd = rd_en && ext_sel;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[B_UR]    = cir && tx_underrun_ev;
    clr_v[B_UR]    = !cir || tx_soft_rst || (aux_wr && wdata[B_UR]);
    set_v[B_EOT]   = aux_wr && wdata[B_EOT];
    clr_v[B_EOT]   = tx_soft_rst || tx_eot_sent || tx_fifo_wr;
    set_v[B_RXACT] = rx_pulse_ev;
    clr_v[B_RXACT] = rx_soft_rst || (aux_wr && wdata[B_RXACT]);
    set_v[B_WDG]   = rx_pulse_ev;
    clr_v[B_WDG]   = rx_soft_rst || (aux_rd && aux_q[B_WDG]);
    set_v[B_TOUT]  = rx_timeout_ev && rx_below_thr;
    clr_v[B_TOUT]  = rx_soft_rst || rx_fifo_rd;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_flag
      uart_aux_flag u_flag (
        .clk   (clk),
        .rst_n (rst_int_n),
        .set_i (set_v[i]),
        .clr_i (clr_v[i]),
        .q_o   (aux_q[i])
      );
    end else begin : g_rsvd
      assign aux_q[i] = 1'b0;
    end
  end

  uart_aux_scratch #(.WIDTH(W)) u_scratch (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we_i  (wr_en && !ext_sel),
    .d_i   (wdata),
    .q_o   (scr_q)
  );

  assign rdata     = ext_sel ? aux_q : scr_q;
  assign eot_req   = aux_q[B_EOT];
  assign rx_enable = aux_q[B_RXACT];

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    ext_sel |-> ((rdata & ~IMPL_MASK) == '0)); // R2
  AST_UR_NONCIR: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cir |=> !aux_q[B_UR]); // R3
  AST_EOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_fifo_wr && !(aux_wr && wdata[B_EOT])) |=> !eot_req); // R4
  AST_RXEN_OFF: assert property (@(posedge clk) disable iff (!rst_int_n)
    (aux_wr && wdata[B_RXACT] && !rx_pulse_ev) |=> !rx_enable); // R5
  AST_WDG_RDCLR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (aux_rd && !rx_pulse_ev) |=> !aux_q[B_WDG]); // R6
  AST_TOUT_GATE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!aux_q[B_TOUT] && !rx_below_thr) |=> !aux_q[B_TOUT]); // R7
  AST_RXSOFT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_soft_rst && !rx_pulse_ev) |=> (!aux_q[B_WDG] && !aux_q[B_RXACT])); // R8
endmodule

// File: tb/uart_aux_slot_tb.sv
module uart_aux_slot_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_sel, wr_en, rd_en;
  logic [2:0] mode;
  logic [7:0] wdata, rdata;
  logic       tx_underrun_ev, tx_soft_rst, tx_eot_sent, tx_fifo_wr;
  logic       rx_pulse_ev, rx_soft_rst, rx_timeout_ev, rx_below_thr, rx_fifo_rd;
  logic       eot_req, rx_enable;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  uart_aux_slot u_dut (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .mode(mode),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .tx_underrun_ev(tx_underrun_ev), .tx_soft_rst(tx_soft_rst),
    .tx_eot_sent(tx_eot_sent), .tx_fifo_wr(tx_fifo_wr),
    .rx_pulse_ev(rx_pulse_ev), .rx_soft_rst(rx_soft_rst),
    .rx_timeout_ev(rx_timeout_ev), .rx_below_thr(rx_below_thr),
    .rx_fifo_rd(rx_fifo_rd), .eot_req(eot_req), .rx_enable(rx_enable)
  );

  // vector: req[4] ext[1] mode[3] wr[1] rd[1] wdata[8] ev[8] exp[8]
  // ev: 0 underrun,1 tx_soft,2 eot_sent,3 tx_fifo_wr,4 pulse,5 rx_soft,6 timeout,7 fifo_rd
  localparam int NV = 25;
  localparam logic [33:0] VEC [NV] = '{
    {4'd1,  1'b0, 3'd2, 1'b1, 1'b0, 8'h5A, 8'h00, 8'h5A}, // R1 scratch write
    {4'd3,  1'b1, 3'd2, 1'b0, 1'b0, 8'h00, 8'h01, 8'h40}, // R3 underrun set
    {4'd3,  1'b1, 3'd2, 1'b1, 1'b0, 8'h00, 8'h00, 8'h40}, // R3 zeros ignored
    {4'd2,  1'b1, 3'd2, 1'b1, 1'b0, 8'h8F, 8'h00, 8'h44}, // R2 rsvd/RO ignored, R4 set
    {4'd4,  1'b1, 3'd2, 1'b0, 1'b0, 8'h00, 8'h08, 8'h40}, // R4 fifo write clears
    {4'd3,  1'b1, 3'd2, 1'b1, 1'b0, 8'h40, 8'h00, 8'h00}, // R3 write-one clear
    {4'd5,  1'b1, 3'd2, 1'b0, 1'b0, 8'h00, 8'h10, 8'h30}, // R5 pulse sets 5,4
    {4'd6,  1'b1, 3'd2, 1'b0, 1'b1, 8'h00, 8'h00, 8'h20}, // R6 read clears wdg
    {4'd7,  1'b1, 3'd2, 1'b0, 1'b0, 8'h00, 8'h40, 8'h21}, // R7 timeout set
    {4'd7,  1'b1, 3'd2, 1'b1, 1'b0, 8'h01, 8'h00, 8'h21}, // R7 read-only
    {4'd7,  1'b1, 3'd2, 1'b0, 1'b0, 8'h00, 8'h80, 8'h20}, // R7 fifo read clears
    {4'd5,  1'b1, 3'd2, 1'b1, 1'b0, 8'h20, 8'h00, 8'h00}, // R5 write-one clears, rx off
    {4'd9,  1'b1, 3'd2, 1'b0, 1'b1, 8'h00, 8'h10, 8'h30}, // R9 pulse vs read
    {4'd9,  1'b1, 3'd2, 1'b0, 1'b0, 8'h00, 8'h60, 8'h01}, // R9 timeout vs rx_soft, R8
    {4'd8,  1'b1, 3'd2, 1'b0, 1'b0, 8'h00, 8'h20, 8'h00}, // R8 rx soft reset
    {4'd4,  1'b1, 3'd2, 1'b1, 1'b0, 8'h04, 8'h00, 8'h04}, // R4 set
    {4'd4,  1'b1, 3'd2, 1'b0, 1'b0, 8'h00, 8'h04, 8'h00}, // R4 eot sent clears
    {4'd4,  1'b1, 3'd2, 1'b1, 1'b0, 8'h04, 8'h00, 8'h04}, // R4 set
    {4'd4,  1'b1, 3'd2, 1'b0, 1'b0, 8'h00, 8'h02, 8'h00}, // R4 tx soft clears
    {4'd10, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00, 8'h01, 8'h00}, // R10 not CIR, no set
    {4'd10, 1'b1, 3'd2, 1'b0, 1'b0, 8'h00, 8'h01, 8'h40}, // R10 CIR code sets
    {4'd3,  1'b1, 3'd1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00}, // R3 other mode forces 0
    {4'd9,  1'b1, 3'd2, 1'b1, 1'b0, 8'h04, 8'h08, 8'h04}, // R9 eot write vs fifo write
    {4'd4,  1'b1, 3'd2, 1'b0, 1'b0, 8'h00, 8'h02, 8'h00}, // R4 tx soft clears
    {4'd1,  1'b0, 3'd2, 1'b0, 1'b0, 8'h00, 8'h00, 8'h5A}  // R1 scratch kept
  };

  task automatic idle();
    wr_en = 0; rd_en = 0; wdata = 8'h00;
    tx_underrun_ev = 0; tx_soft_rst = 0; tx_eot_sent = 0; tx_fifo_wr = 0;
    rx_pulse_ev = 0; rx_soft_rst = 0; rx_timeout_ev = 0; rx_fifo_rd = 0;
  endtask

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0; ext_sel = 1; mode = 3'd2; rx_below_thr = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R2 reset state of both registers
    check(2, rdata, 8'h00);
    ext_sel = 0; #1;
    check(2, rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      ext_sel = v[29]; mode = v[28:26]; wr_en = v[25]; rd_en = v[24];
      wdata = v[23:16];
      {rx_fifo_rd, rx_timeout_ev, rx_soft_rst, rx_pulse_ev,
       tx_fifo_wr, tx_eot_sent, tx_soft_rst, tx_underrun_ev} = v[15:8];
      @(negedge clk);
      idle();
      #1;
      check(int'(v[33:30]), rdata, v[7:0]);
      if (v[29]) begin
        check(int'(v[33:30]), {6'd0, rx_enable, eot_req}, {6'd0, v[5], v[2]});
      end
    end

    // R7 timeout ignored when not below threshold
    ext_sel = 1; mode = 3'd2; rx_below_thr = 0; rx_timeout_ev = 1;
    @(negedge clk); idle(); #1;
    check(7, rdata, 8'h00);
    rx_below_thr = 1;
    // R6 read with scratch selected leaves watchdog alone
    rx_pulse_ev = 1; @(negedge clk); idle();
    ext_sel = 0; rd_en = 1; @(negedge clk); idle(); ext_sel = 1; #1;
    check(6, rdata, 8'h30);
    check(5, {7'd0, rx_enable}, 8'h01);
    // R2 reset mid-run clears status, scratch
    rst_n = 0; @(negedge clk); #1;
    check(2, rdata, 8'h00);
    ext_sel = 0; #1;
    check(2, rdata, 8'h00);
    rst_n = 1; repeat (3) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule